// File: doc/BRIEF.md
# DMA Page Table Translator

This block turns a 32-bit address issued by a DMA engine into a physical address. It walks a single-level table kept in system memory. The upper bits of the incoming address select a table slot, and the block reads that slot over a simple memory-read port. The frame held in the slot replaces the page number, and the low 12 bits of the incoming address pass through unchanged.

Software programs two registers through a write-only register port: the table origin and the table length in bytes. A third register offset accepts a write that flushes cached entries. This block keeps no cache, so it ignores that write. A request that falls beyond the table, or whose table read fails, returns a fault with no usable address. The block handles one request at a time and raises `busy` until the answer has gone out.

Top module: `dma_page_xlate`

## Requirements
- R1: An incoming address splits into a page index (address bits 31:12) and a page offset (bits 11:0). The offset appears unchanged in bits 11:0 of every non-faulting result.
- R2: For an in-range index, the block raises `mem_rd` with `mem_addr` = (origin AND 0x7FFF_FFFF) + index × 8, modulo 2^32. It holds both steady until a cycle with `mem_rvalid` high.
- R3: The length register counts bytes. An index is in range only when index < floor(length / 8). An out-of-range request returns a fault and never raises `mem_rd`.
- R4: On a good table read, the result is bits 31:12 of the frame word `mem_rdata[31:0]` joined with the page offset. The owner word `mem_rdata[63:32]` has no effect on the result.
- R5: A table read returned with `mem_rerr` high produces a fault response.
- R6: Each accepted request yields exactly one `rsp_valid` pulse, one cycle long. Every faulting response carries `rsp_addr` = 0.
- R7: A request is accepted only while `busy` is low. `busy` rises on the edge that accepts a request and falls on the edge after the response pulse. A `req_valid` seen while busy is dropped: it causes no table read and no response.
- R8: A register write with `reg_addr` 0x0 loads the origin and 0x4 loads the length. Writes to 0x8 (the flush offset) and to any other offset change no translation result.
- R9: After reset, `busy`, `mem_rd` and `rsp_valid` are low, origin and length are 0, and every request faults without a table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Device-side DMA address |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | No permission: out of range or failed read |
| mem_rd | output | 1 | Table read request, held until answered |
| mem_addr | output | 32 | Table slot byte address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 64 | Slot contents: frame word in 31:0, owner word in 63:32 |
| mem_rerr | input | 1 | Table read failed |

## Verification
The bound checker watches the following on every cycle:
- the response pulse is a single cycle long;
- faults carry a zero address;
- a read request stays steady until it is answered;
- an answered read leads to a response on the next edge whose fault flag matches the error flag;
- no read is issued outside a busy period.

Only the bench scenarios can show that the arithmetic is correct. They sweep the index across the table length, including lengths that are not multiples of 8. They also cover the origin masking, the offset pass-through, the independence from the owner word, the flush and unknown register offsets, and a request dropped while busy.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_RESP  = 2'd2
   } walk_state_e;

   localparam int unsigned OFS_ORIGIN = 0;
   localparam int unsigned OFS_LENGTH = 4;
   localparam int unsigned OFS_FLUSH  = 8;
endpackage

// File: rtl/dpx_cfg_regs.sv
module dpx_cfg_regs #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned REG_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] origin_q,
   output logic [ADDR_W-1:0] length_q
);
   import dpx_pkg::*;

   localparam logic [REG_AW-1:0] A_ORIGIN = REG_AW'(OFS_ORIGIN);
   localparam logic [REG_AW-1:0] A_LENGTH = REG_AW'(OFS_LENGTH);
   localparam logic [REG_AW-1:0] A_FLUSH  = REG_AW'(OFS_FLUSH);

   initial begin
      if (REG_AW < 4) $error("REG_AW must cover offset 0x8");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         origin_q <= '0;
         length_q <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            A_ORIGIN: origin_q <= reg_wdata;
            A_LENGTH: length_q <= reg_wdata;
            A_FLUSH:  ;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/dpx_addr_calc.sv
module dpx_addr_calc #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned ENTRY_SHIFT = 3,
   parameter bit          USE_MASK    = 1'b1,
   parameter logic [ADDR_W-1:0] ORIGIN_MASK = 32'h7FFF_FFFF
) (
   input  logic [ADDR_W-1:0]    dma_addr,
   input  logic [ADDR_W-1:0]    origin,
   input  logic [ADDR_W-1:0]    length,
   output logic                 in_range,
   output logic [ADDR_W-1:0]    slot_addr,
   output logic [PAGE_BITS-1:0] page_off
);
   localparam int unsigned IDX_W = ADDR_W - PAGE_BITS;

   logic [IDX_W-1:0]  index;
   logic [ADDR_W-1:0] slots;
   logic [ADDR_W-1:0] eff_origin;

   initial begin
      if (PAGE_BITS >= ADDR_W) $error("PAGE_BITS must be below ADDR_W");
      if (ENTRY_SHIFT >= ADDR_W) $error("ENTRY_SHIFT too large");
   end

   assign index    = dma_addr[ADDR_W-1:PAGE_BITS];
   assign page_off = dma_addr[PAGE_BITS-1:0];
   assign slots    = length >> ENTRY_SHIFT;
   assign in_range = ADDR_W'(index) < slots;

   generate
      if (USE_MASK) begin : g_mask
         assign eff_origin = origin & ORIGIN_MASK;
      end else begin : g_nomask
         assign eff_origin = origin;
      end
   endgenerate

   assign slot_addr = eff_origin + (ADDR_W'(index) << ENTRY_SHIFT);
endmodule

// File: rtl/dpx_walk_fsm.sv
module dpx_walk_fsm #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PAGE_BITS  = 12,
   parameter int unsigned MEM_W      = 64,
   parameter int unsigned FRAME_LANE = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 in_range,
   input  logic [ADDR_W-1:0]    slot_addr,
   input  logic [PAGE_BITS-1:0] page_off,
   input  logic                 mem_rvalid,
   input  logic [MEM_W-1:0]     mem_rdata,
   input  logic                 mem_rerr,
   output logic                 busy,
   output logic                 mem_rd,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic                 rsp_valid,
   output logic [ADDR_W-1:0]    rsp_addr,
   output logic                 rsp_fault
);
   import dpx_pkg::*;

   localparam int unsigned LANES = MEM_W / ADDR_W;

   walk_state_e          st_q;
   logic [PAGE_BITS-1:0] off_q;
   logic [ADDR_W-1:0]    frame_w;
   logic                 unused_rd;

   initial begin
      if (MEM_W % ADDR_W != 0) $error("MEM_W must be a multiple of ADDR_W");
      if (FRAME_LANE >= LANES) $error("FRAME_LANE out of range");
   end

   generate
      if (LANES == 1) begin : g_one
         assign frame_w = mem_rdata[ADDR_W-1:0];
      end else begin : g_lane
         assign frame_w = mem_rdata[FRAME_LANE*ADDR_W +: ADDR_W];
      end
   endgenerate

   assign unused_rd = ^mem_rdata ^ ^frame_w[PAGE_BITS-1:0];
   assign busy      = (st_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         off_q     <= '0;
         mem_rd    <= 1'b0;
         mem_addr  <= '0;
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_fault <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  off_q <= page_off;
                  if (in_range) begin
                     mem_addr <= slot_addr;
                     mem_rd   <= 1'b1;
                     st_q     <= ST_FETCH;
                  end else begin
                     rsp_valid <= 1'b1;
                     rsp_fault <= 1'b1;
                     rsp_addr  <= '0;
                     st_q      <= ST_RESP;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_rvalid) begin
                  mem_rd    <= 1'b0;
                  rsp_valid <= 1'b1;
                  st_q      <= ST_RESP;
                  if (mem_rerr) begin
                     rsp_fault <= 1'b1;
                     rsp_addr  <= '0;
                  end else begin
                     rsp_fault <= 1'b0;
                     rsp_addr  <= {frame_w[ADDR_W-1:PAGE_BITS], off_q};
                  end
               end
            end
            default: begin
               rsp_valid <= 1'b0;
               st_q      <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/dma_page_xlate.sv
module dma_page_xlate #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned ENTRY_BYTES = 8,
   parameter int unsigned MEM_W       = 64,
   parameter int unsigned REG_AW      = 4,
   parameter bit          USE_MASK    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              busy,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_fault,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [MEM_W-1:0]  mem_rdata,
   input  logic              mem_rerr
);
   localparam int unsigned ENTRY_SHIFT = $clog2(ENTRY_BYTES);
   localparam logic [ADDR_W-1:0] ORIGIN_MASK = {1'b0, {(ADDR_W-1){1'b1}}};

   logic [ADDR_W-1:0]    origin_q;
   logic [ADDR_W-1:0]    length_q;
   logic                 in_range;
   logic [ADDR_W-1:0]    slot_addr;
   logic [PAGE_BITS-1:0] page_off;
   logic                 take;

   initial begin
      if ((1 << ENTRY_SHIFT) != ENTRY_BYTES) $error("ENTRY_BYTES must be a power of two");
      if (ENTRY_BYTES * 8 > MEM_W) $error("entry wider than read port");
   end

   assign take = req_valid & ~busy;

   dpx_cfg_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .origin_q(origin_q), .length_q(length_q)
   );

   dpx_addr_calc #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRY_SHIFT(ENTRY_SHIFT),
      .USE_MASK(USE_MASK), .ORIGIN_MASK(ORIGIN_MASK)
   ) u_calc (
      .dma_addr(req_addr), .origin(origin_q), .length(length_q),
      .in_range(in_range), .slot_addr(slot_addr), .page_off(page_off)
   );

   dpx_walk_fsm #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .MEM_W(MEM_W), .FRAME_LANE(0)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .req_valid(take), .in_range(in_range),
      .slot_addr(slot_addr), .page_off(page_off), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .busy(busy), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
      .rsp_fault(rsp_fault)
   );
endmodule

// File: rtl/dpx_chk.sv
module dpx_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic              rsp_fault,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              mem_rerr
);
   // R6
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R6
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));

   // R5
   rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_rvalid) |=> (rsp_valid && rsp_fault == $past(mem_rerr)));

   // R7
   rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy);

   // R7
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   // R7
   idle_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !busy);
endmodule

bind dma_page_xlate dpx_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
   .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
   .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
   .mem_rerr(mem_rerr)
);

// File: tb/sim_dma_page_xlate.sv
`timescale 1ns/1ps
module sim_dma_page_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        busy, rsp_valid, rsp_fault, mem_rd;
   logic [31:0] rsp_addr, mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        mem_rerr = 1'b0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;
   logic [31:0] origin_m = 0, length_m = 0;

   always #2.5 clk = ~clk;

   dma_page_xlate u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .req_valid(req_valid), .req_addr(req_addr),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
      .rsp_fault(rsp_fault), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr)
   );

   function automatic logic [31:0] frame_of(logic [31:0] ea);
      return ea ^ 32'h5A5A_3C3C;
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (a == 4'h0) origin_m = d;
      if (a == 4'h4) length_m = d;
   endtask

   // Runs one translation; answers the table read with owner word own_w.
   task automatic xl(logic [31:0] a, bit err, logic [31:0] own_w,
                     output logic [31:0] got, output bit flt,
                     output int nf, output logic [31:0] fa);
      bit answered = 0;
      nf = 0; fa = 0; got = 0; flt = 0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
         mem_rvalid = 1'b0;
         if (rsp_valid) begin
            got = rsp_addr; flt = rsp_fault;
            break;
         end
         if (mem_rd && !answered) begin
            answered = 1; nf++; fa = mem_addr;
            mem_rvalid = 1'b1; mem_rerr = err;
            mem_rdata = {own_w, frame_of(mem_addr)};
         end
      end
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rerr = 1'b0;
   endtask

   // Computes the expected outcome and compares.
   task automatic run(logic [31:0] a, bit err, string tag);
      logic [31:0] got, fa, ea, exp_a;
      bit flt, exp_f;
      int nf;
      logic [31:0] idx, slots;
      idx = a >> 12;
      slots = length_m >> 3;
      ea = (origin_m & 32'h7FFF_FFFF) + (idx << 3);
      xl(a, err, 32'hFFFF_FFFF ^ a, got, flt, nf, fa);
      if (idx < slots) begin
         chk(nf == 1, {tag, " R2 fetch count"}, nf, 1);
         chk(fa == ea, {tag, " R2 slot address"}, fa, ea);
         exp_f = err;
         exp_a = err ? 32'h0 : {frame_of(ea)[31:12], a[11:0]};
      end else begin
         chk(nf == 0, {tag, " R3 no fetch"}, nf, 0);
         exp_f = 1; exp_a = 0;
      end
      chk(flt == exp_f, {tag, " R5 fault"}, flt, exp_f);
      chk(got == exp_a, {tag, " R4 result"}, got, exp_a);
      chk(!busy, {tag, " R7 idle after"}, busy, 0);
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin : main
      logic [31:0] got, fa, first;
      bit flt;
      int nf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(!busy && !rsp_valid && !mem_rd, "R9 reset outputs",
          {busy, rsp_valid, mem_rd}, 0);
      run(32'h0000_0123, 0, "R9 post-reset");
      run(32'h0004_5678, 0, "R9 post-reset");

      // R1 R2 R3 R4: origin with bit 31 set, length not a multiple of 8
      wr(4'h0, 32'h8012_3000);
      wr(4'h4, 32'h0000_0083);
      for (int i = 0; i < 20; i++)
         run((i << 12) | ((i * 32'h1D3) & 32'hFFF), 0, "R1 sweep");

      // R5 failed reads
      run(32'h0000_3ABC, 1, "R5 error");
      run(32'h0000_F001, 1, "R5 error");

      // R3 length boundaries
      wr(4'h4, 32'h0);
      run(32'h0000_0FFF, 0, "R3 zero length");
      wr(4'h4, 32'h8);
      run(32'h0000_0AAA, 0, "R3 one slot");
      run(32'h0000_1AAA, 0, "R3 one slot");
      wr(4'h4, 32'hF);
      run(32'h0000_1000, 0, "R3 partial slot");

      // R2 wrap with full length and top index
      wr(4'h0, 32'h7FF0_0004);
      wr(4'h4, 32'hFFFF_FFFF);
      run(32'hFFFF_F123, 0, "R2 top index");
      run(32'h8000_0FED, 0, "R2 high index");

      // R8 flush offset and unknown offset have no effect
      wr(4'h0, 32'h0001_0000);
      wr(4'h4, 32'h0000_0100);
      run(32'h0000_5321, 0, "R8 before");
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h0;
      @(negedge clk);
      reg_addr = 4'hC; reg_wdata = 32'h0;
      @(negedge clk);
      reg_we = 1'b0;
      run(32'h0000_5321, 0, "R8 after flush");
      run(32'h0001_F000, 0, "R8 length kept");

      // R4 owner word ignored
      xl(32'h0000_2777, 0, 32'h0, first, flt, nf, fa);
      xl(32'h0000_2777, 0, 32'h1234_5678, got, flt, nf, fa);
      chk(got == first, "R4 owner ignored", got, first);

      // R7 request while busy dropped
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0000_4010;
      @(negedge clk);
      chk(busy && mem_rd, "R7 busy during fetch", {busy, mem_rd}, 2'b11);
      req_addr = 32'h0000_9999;
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_rd && !rsp_valid, "R7 still waiting", {mem_rd, rsp_valid}, 2'b10);
      fa = mem_addr;
      chk(fa == 32'h0001_0020, "R7 first slot kept", fa, 32'h0001_0020);
      mem_rvalid = 1'b1; mem_rdata = {32'h0, frame_of(fa)};
      @(negedge clk);
      mem_rvalid = 1'b0;
      chk(rsp_valid && !rsp_fault && rsp_addr == {frame_of(32'h0001_0020)[31:12], 12'h010},
          "R7 response of first", rsp_addr, {frame_of(32'h0001_0020)[31:12], 12'h010});
      @(negedge clk);
      chk(!rsp_valid, "R6 single pulse", rsp_valid, 0);
      nf = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (mem_rd || rsp_valid) nf++;
      end
      chk(nf == 0 && !busy, "R7 dropped request", nf, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule